// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

The block is a watchdog that counts ticks from a system-counter tick-enable input. Software programs a 32-bit interval, the offset, and then sets an enable bit. Once enabled, the watchdog counts the offset number of ticks and then raises a warning level that drives an interrupt line. If software still does not refresh it, the watchdog counts a second interval of the same length and then raises a reset-request level.

Software restarts the sequence with a write to the refresh register, whatever the data. A write to the offset register also restarts it. The registers sit behind a single-cycle read/write port that has a frame select. Frame 0 is the 4 KiB control frame and frame 1 is the 4 KiB refresh frame. Read data is combinational and is valid in the same cycle as the request. Writes take effect at the clock edge that samples them.

Top module: `dual_stage_wdt`

## Requirements
- R1: After reset, `irq_warn` and `rst_req` are low, the enable bit is 0 and the offset register holds 0.
- R2: Counting starts from enable (the enable bit goes from 0 to 1) or from a refresh. On the tick that brings the count to the offset, `irq_warn` rises. For an offset of 0 this is the first tick.
- R3: If no refresh follows, `rst_req` rises on the tick that completes a second interval of the same length. `irq_warn` stays high while `rst_req` is high. Both then hold until a refresh or a disable.
- R4: Any write to offset 0x000 of the refresh frame (`bus_frame`=1) restarts the sequence, whatever the data. The restart clears `irq_warn` and `rst_req`. A write to any other refresh-frame offset has no effect.
- R5: A write to the offset register (control frame, offset 0x008) loads the new interval and also restarts the sequence.
- R6: The count advances only on cycles where `tick_en` is high while the enable bit is set. On other cycles the outputs hold.
- R7: Writing 0 to the enable bit (control frame 0x000, bit 0) stops counting and drops both outputs in the same edge. Setting the bit again starts a fresh first-stage interval.
- R8: With an offset of 0, `irq_warn` and then `rst_req` rise on two consecutive ticks.
- R9: Reads are as follows. Control frame 0x000 reads {29'b0, stage-2 flag, stage-1 flag, enable} in bits [2:0]. Control frame 0x008 reads the offset. Every other address reads 0. A control-frame write to any other offset changes nothing.
- R10: A tick that arrives in the same cycle as a refresh write is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | System-counter tick enable |
| bus_req | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_frame | input | 1 | 0 = control frame, 1 = refresh frame |
| bus_addr | input | 12 | Byte offset within the frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the request |
| irq_warn | output | 1 | First-stage expiry, interrupt |
| rst_req | output | 1 | Second-stage expiry, reset request |

## Verification
A tick or a write driven in one cycle changes `irq_warn` and `rst_req` at the very next clock edge. The bench drives every input on the falling edge and checks the outputs on the following falling edge, which is exactly one register stage later. Read data has no register stage, so the bench samples it shortly after it drives the request, within the same low clock phase. The bench sweeps offsets 0 to 6 with ticks on every cycle and with ticks spaced by idle cycles. For each tick it computes the expected stage from the tick count and max(offset, 1).

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_CTRL    = 12'h000;
  localparam logic [ADDR_W-1:0] A_OFFSET  = 12'h008;
  localparam logic [ADDR_W-1:0] A_REFRESH = 12'h000;
  typedef enum logic {FR_CTRL = 1'b0, FR_REFRESH = 1'b1} frame_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_frame,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              st_ws0,
  input  logic              st_ws1,
  output logic              en_q,
  output logic              en_nxt,
  output logic [CNT_W-1:0]  offset_q,
  output logic              restart
);
  frame_e frame;
  logic wr, wr_ctrl, wr_off, wr_ref;

  assign frame   = frame_e'(bus_frame);
  assign wr      = bus_req && bus_we;
  assign wr_ctrl = wr && (frame == FR_CTRL) && (bus_addr == A_CTRL);
  assign wr_off  = wr && (frame == FR_CTRL) && (bus_addr == A_OFFSET);
  assign wr_ref  = wr && (frame == FR_REFRESH) && (bus_addr == A_REFRESH);

  assign en_nxt  = wr_ctrl ? bus_wdata[0] : en_q;
  // restart on refresh, offset load, or a 0->1 enable edge
  assign restart = wr_ref || wr_off || (en_nxt && !en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      offset_q <= '0;
    end else begin
      en_q <= en_nxt;
      if (wr_off) offset_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_req && !bus_we && frame == FR_CTRL) begin
      if (bus_addr == A_CTRL)        bus_rdata[2:0] = {st_ws1, st_ws0, en_q};
      else if (bus_addr == A_OFFSET) bus_rdata[CNT_W-1:0] = offset_q;
    end
  end

  // R5: an offset write always loads the data seen on the bus
  p_offset_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_off |=> (offset_q == $past(bus_wdata[CNT_W-1:0])));
endmodule

// File: rtl/wdt_stage_cnt.sv
module wdt_stage_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic [CNT_W-1:0] offset,
  output logic             ws0,
  output logic             ws1
);
  logic [CNT_W-1:0] cnt;
  logic             hit;

  // expiry when the tick about to be counted reaches the offset (0 -> first tick)
  assign hit = ({1'b0, cnt} + 1'b1) >= {1'b0, offset};

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt <= '0;
      ws0 <= 1'b0;
      ws1 <= 1'b0;
    end else if (tick && !ws1) begin
      if (hit) begin
        cnt <= '0;
        if (!ws0) ws0 <= 1'b1;
        else      ws1 <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: second stage only follows the first
  p_ws1_after_ws0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ws1 |-> ws0);
  // R4: a restart leaves both stages clear
  p_clear_quiets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!ws0 && !ws1));
  // R6: without a tick nothing moves
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear) |=> ($stable(cnt) && $stable(ws0) && $stable(ws1)));
  // R2: first stage rises only on a counted tick
  p_rise_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ws0) |-> $past(tick));
endmodule

// File: rtl/dual_stage_wdt.sv
module dual_stage_wdt
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_frame,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_warn,
  output logic              rst_req
);
  logic en_q, en_nxt, restart, ws0, ws1;
  logic [CNT_W-1:0] offset_q;

  wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_frame(bus_frame), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .st_ws0(ws0), .st_ws1(ws1), .en_q(en_q),
    .en_nxt(en_nxt), .offset_q(offset_q), .restart(restart)
  );

  wdt_stage_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_en && en_q),
    .clear(restart || !en_nxt), .offset(offset_q), .ws0(ws0), .ws1(ws1)
  );

  assign irq_warn = ws0;
  assign rst_req  = ws1;

  // R7: nothing is signalled while disabled
  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!irq_warn && !rst_req));
endmodule

// File: tb/dual_stage_wdt_tb.sv
module dual_stage_wdt_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0, bus_frame = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_warn, rst_req;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  dual_stage_wdt u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_req(bus_req),
    .bus_we(bus_we), .bus_frame(bus_frame), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_warn(irq_warn), .rst_req(rst_req)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_out(string req, bit e0, bit e1);
    chk(req, {30'b0, rst_req, irq_warn}, {30'b0, e1, e0});
  endtask

  // call at a negedge; returns at the next negedge
  task automatic wr(bit fr, logic [11:0] a, logic [31:0] d, bit tk = 1'b0);
    bus_req = 1; bus_we = 1; bus_frame = fr; bus_addr = a; bus_wdata = d; tick_en = tk;
    @(negedge clk);
    bus_req = 0; bus_we = 0; tick_en = 0;
  endtask

  task automatic rd(bit fr, logic [11:0] a, output logic [31:0] d);
    bus_req = 1; bus_we = 0; bus_frame = fr; bus_addr = a;
    #1 d = bus_rdata;
    bus_req = 0;
  endtask

  task automatic cyc(bit tk);
    tick_en = tk;
    @(negedge clk);
    tick_en = 0;
  endtask

  task automatic run_case(int n, int gap);
    int e;
    string tag;
    e = (n == 0) ? 1 : n;
    tag = (n == 0) ? "R8" : "R2/R3";
    wr(0, 12'h000, 0);
    wr(0, 12'h008, n);
    wr(0, 12'h000, 1);
    chk_out("R2 start", 0, 0);
    for (int t = 1; t <= 2 * e + 1; t++) begin
      for (int g = 0; g < gap; g++) cyc(0);
      if (gap > 0) chk_out("R6 idle hold", (t - 1) >= e, (t - 1) >= 2 * e);
      cyc(1);
      chk_out(tag, t >= e, t >= 2 * e);
    end
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_out("R1 outputs", 0, 0);
    rd(0, 12'h000, d); chk("R1 status", d, 0);
    rd(0, 12'h008, d); chk("R1 offset", d, 0);

    for (int n = 0; n <= 6; n++) begin
      run_case(n, 0);
      run_case(n, 2);
    end

    // R9 status after both stages (n=6 case left ws1 set)
    rd(0, 12'h000, d); chk("R9 status", d, 32'h7);
    rd(0, 12'h008, d); chk("R9 offset", d, 6);
    rd(0, 12'h004, d); chk("R9 unmapped", d, 0);
    rd(1, 12'h000, d); chk("R9 refresh frame read", d, 0);
    wr(0, 12'h010, 32'h0);
    rd(0, 12'h000, d); chk("R9 ignored ctrl write", d, 32'h7);

    // R4 ignored refresh offset, then real refresh with odd data
    wr(1, 12'h004, 32'h0);
    chk_out("R4 ignored refresh", 1, 1);
    wr(1, 12'h000, 32'hdead_beef);
    chk_out("R4 refresh clears", 0, 0);
    for (int t = 1; t <= 6; t++) begin cyc(1); chk_out("R4 after refresh", t >= 6, 0); end

    // R5 offset write restarts with new interval (ws0 currently high)
    wr(0, 12'h008, 3);
    chk_out("R5 offset restart", 0, 0);
    for (int t = 1; t <= 6; t++) begin cyc(1); chk_out("R5 new interval", t >= 3, t >= 6); end

    // R7 disable drops outputs, no counting while off, fresh interval on enable
    wr(0, 12'h000, 0);
    chk_out("R7 disable", 0, 0);
    for (int t = 0; t < 8; t++) cyc(1);
    chk_out("R7 no count disabled", 0, 0);
    rd(0, 12'h000, d); chk("R7 status off", d, 0);
    wr(0, 12'h000, 1);
    cyc(1); cyc(1); chk_out("R7 fresh interval", 0, 0);
    wr(0, 12'h000, 1);   // already enabled: no restart
    cyc(1); chk_out("R7 re-set keeps count", 1, 0);

    // R10 tick coinciding with refresh is dropped (offset 3)
    wr(1, 12'h000, 0);
    cyc(1); cyc(1);
    wr(1, 12'h000, 0, 1'b1);
    cyc(1); cyc(1); chk_out("R10 tick dropped", 0, 0);
    cyc(1); chk_out("R10 expiry", 1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule